// File: doc/BRIEF.md
# Vectored Interrupt Mask and Pending Unit

This unit is the interrupt front end of a small 8-bit processor core. It takes five request inputs:
- one non-maskable request,
- three maskable vectored requests (high, middle and low),
- one maskable non-vectored request.

It keeps a global interrupt-enable flag and a 3-bit mask register. It also holds an edge latch for the high vectored request and a re-arm gate for the non-maskable request. The core pulses a strobe at each instruction boundary. On that strobe the unit picks the most urgent eligible request. On the next cycle it reports the source code and the 16-bit service vector. For the non-vectored request it raises an acknowledge pulse instead of giving a vector.

The core drives the following inputs:
- Enable and disable strobes, which set and clear the global flag.
- A 5-bit command write, which is the low part of the set-mask byte. One bit of the byte lets the command load the masks. Another bit clears the high edge latch.

The core reads an 8-bit status byte. It shows the masks, the global flag, the three pending vectored requests and a serial input bit that is passed straight through.

Top module: `vec_irq_unit`

## Requirements
- R1: After rst_ni is asserted, the status byte reads 8'h07: all three masks set, global enable clear, no latch pending, serial bit 0. take_o, ack_o, src_o and vector_o are zero.
- R2: The status byte bits are:
  - bit 0: low mask (1 = masked); bit 1: middle mask; bit 2: high mask.
  - bit 3: global enable.
  - bit 4: low request level; bit 5: middle request level; bit 6: high edge latch.
  - bit 7: serial_i.
  The pending bits ignore the masks and the global enable.
- R3: Requests are sampled only on a clock edge where boundary_i is 1. take_o, src_o and vector_o (and ack_o) are valid in the cycle after that edge, for exactly one cycle. Otherwise take_o is 0, src_o is 0, vector_o is 0 and ack_o is 0.
- R4: The service priority, from highest to lowest, is given below with each source's src_o code and vector_o value:

  | Source | src_o | vector_o |
  |---|---|---|
  | Non-maskable | 5 | 16'h0024 |
  | High vectored | 4 | 16'h003C |
  | Middle vectored | 3 | 16'h0034 |
  | Low vectored | 2 | 16'h002C |
  | Non-vectored | 1 | 16'h0000, with ack_o = 1 |
- R5: The non-maskable request ignores the global enable and the masks. It is accepted only if nmi_i rose and has stayed high since. Once accepted, it is not accepted again until nmi_i goes low and rises again.
- R6: A rising edge on vhi_i sets the high edge latch, so a one-cycle pulse is enough. The latch clears in either of two cases:
  - the high vectored request is serviced;
  - a command write has bit 4 = 1.

  A new rising edge in the same cycle keeps the latch set.
- R7: The middle and low requests are level sensitive. They count only if the input is high at the boundary edge, and nothing is latched.
- R8: On a command write (cmd_wr_i), bit 3 = 1 loads bits 2..0 into the high, middle and low masks. With bit 3 = 0 the masks are unchanged.
- R9: The global enable is changed as follows:
  - en_op_i sets it and dis_op_i clears it; dis_op_i wins when both are high.
  - Acceptance of any maskable request (vectored or non-vectored) clears it, and this takes precedence over en_op_i.
  - Acceptance of the non-maskable request leaves it unchanged.
- R10: A vectored maskable request is eligible only when the global enable is 1 and its own mask bit is 0. The non-vectored request needs only the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary sampling strobe |
| nmi_i | input | 1 | Non-maskable request (level plus edge) |
| vhi_i | input | 1 | High vectored request (edge) |
| vmid_i | input | 1 | Middle vectored request (level) |
| vlo_i | input | 1 | Low vectored request (level) |
| nvec_i | input | 1 | Non-vectored maskable request (level) |
| en_op_i | input | 1 | Set global enable |
| dis_op_i | input | 1 | Clear global enable |
| cmd_wr_i | input | 1 | Command byte write strobe |
| cmd_i | input | 5 | Command bits 4..0 |
| serial_i | input | 1 | Serial bit shown in status bit 7 |
| status_o | output | 8 | Status byte |
| take_o | output | 1 | Request accepted (one cycle) |
| src_o | output | 3 | Accepted source code |
| vector_o | output | 16 | Service vector |
| ack_o | output | 1 | Non-vectored acknowledge pulse |

## Verification
The assertions check the following on every cycle:
- A result appears only after a boundary edge.
- A maskable acceptance needs the enable that was in force, and it leaves the enable cleared.
- A command with bit 3 = 0 never disturbs the masks.
- Servicing the high input empties its latch unless a fresh edge arrived.
- The acknowledge pulse comes only with the non-vectored code.

Only the bench scenarios can show some behaviours, because they depend on input history that spans many cycles:
- the relative priority of concurrent requests;
- the re-arm rule of the non-maskable input;
- a short pulse on the high input being held;
- the effect of bit 4 on that latch.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int unsigned VEC_W   = 16;
  localparam int unsigned MASK_W  = 3;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned SRC_W   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_NVEC = 3'd1,
    SRC_LO   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_HI   = 3'd4,
    SRC_NMI  = 3'd5
  } irq_src_e;

  // request vector slot order, index 0 = least urgent
  localparam int unsigned SLOT_NVEC = 0;
  localparam int unsigned SLOT_LO   = 1;
  localparam int unsigned SLOT_MID  = 2;
  localparam int unsigned SLOT_HI   = 3;
  localparam int unsigned SLOT_NMI  = 4;

  // command byte bit positions
  localparam int unsigned CMD_LOAD = 3;
  localparam int unsigned CMD_CLR  = 4;

  function automatic irq_src_e slot_to_src(input int unsigned slot);
    case (slot)
      SLOT_NMI: return SRC_NMI;
      SLOT_HI:  return SRC_HI;
      SLOT_MID: return SRC_MID;
      SLOT_LO:  return SRC_LO;
      default:  return SRC_NVEC;
    endcase
  endfunction
endpackage

// File: rtl/irq_nmi_gate.sv
// Level-plus-edge qualifier: arms on rise, disarms on drop or acceptance.
module irq_nmi_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic take_i,
  output logic req_o
);
  logic lvl_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (!lvl_i)            armed_q <= 1'b0;
      else if (!lvl_q)       armed_q <= 1'b1;
      else if (take_i)       armed_q <= 1'b0;
    end
  end

  assign req_o = armed_q & lvl_i;
endmodule

// File: rtl/irq_edge_latch.sv
// Rising-edge capture held until serviced or cleared by command.
module irq_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic take_i,
  input  logic clr_i,
  output logic rise_o,
  output logic pend_o
);
  logic lvl_q, pend_q;

  assign rise_o = lvl_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (rise_o)               pend_q <= 1'b1;
      else if (take_i || clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
// Global enable and per-input masks.
module irq_ctrl_regs #(
  parameter int unsigned MASK_W = 3,
  parameter int unsigned CMD_W  = 5,
  parameter int unsigned LOAD_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_op_i,
  input  logic              dis_op_i,
  input  logic              accept_mskbl_i,
  input  logic              wr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              ie_o,
  output logic [MASK_W-1:0] mask_o
);
  logic              ie_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (accept_mskbl_i || dis_op_i) ie_q <= 1'b0;
      else if (en_op_i)               ie_q <= 1'b1;
      if (wr_i && cmd_i[LOAD_BIT])    mask_q <= cmd_i[MASK_W-1:0];
    end
  end

  assign ie_o   = ie_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed-priority pick: highest index wins.
module irq_prio_sel #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] win_o
);
  logic [N:0] above;

  assign above[N] = 1'b0;
  for (genvar g = N - 1; g >= 0; g--) begin : g_slot
    assign win_o[g] = req_i[g] & ~above[g+1];
    assign above[g] = above[g+1] | req_i[g];
  end
endmodule

// File: rtl/vec_irq_unit.sv
module vec_irq_unit
  import vec_irq_pkg::*;
#(
  parameter int unsigned       VW       = VEC_W,
  parameter logic [VEC_W-1:0]  VEC_NMI  = 16'h0024,
  parameter logic [VEC_W-1:0]  VEC_HI   = 16'h003C,
  parameter logic [VEC_W-1:0]  VEC_MID  = 16'h0034,
  parameter logic [VEC_W-1:0]  VEC_LO   = 16'h002C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boundary_i,
  input  logic          nmi_i,
  input  logic          vhi_i,
  input  logic          vmid_i,
  input  logic          vlo_i,
  input  logic          nvec_i,
  input  logic          en_op_i,
  input  logic          dis_op_i,
  input  logic          cmd_wr_i,
  input  logic [4:0]    cmd_i,
  input  logic          serial_i,
  output logic [7:0]    status_o,
  output logic          take_o,
  output logic [2:0]    src_o,
  output logic [VW-1:0] vector_o,
  output logic          ack_o
);
  localparam int unsigned CMD_W = 5;

  logic              nmi_req, hi_pend, hi_rise, ie;
  logic [MASK_W-1:0] mask;
  logic [NUM_SRC-1:0] req, win, grant;
  logic              any_grant, accept_mskbl;

  logic              take_q, ack_q;
  irq_src_e          src_q, src_d;
  logic [VW-1:0]     vec_q, vec_d;

  assign grant     = boundary_i ? win : '0;
  assign any_grant = |grant;
  assign accept_mskbl = any_grant & ~grant[SLOT_NMI];

  irq_nmi_gate u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (nmi_i),
    .take_i (grant[SLOT_NMI]),
    .req_o  (nmi_req)
  );

  irq_edge_latch u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (vhi_i),
    .take_i (grant[SLOT_HI]),
    .clr_i  (cmd_wr_i & cmd_i[CMD_CLR]),
    .rise_o (hi_rise),
    .pend_o (hi_pend)
  );

  irq_ctrl_regs #(
    .MASK_W   (MASK_W),
    .CMD_W    (CMD_W),
    .LOAD_BIT (CMD_LOAD)
  ) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_op_i        (en_op_i),
    .dis_op_i       (dis_op_i),
    .accept_mskbl_i (accept_mskbl),
    .wr_i           (cmd_wr_i),
    .cmd_i          (cmd_i),
    .ie_o           (ie),
    .mask_o         (mask)
  );

  assign req[SLOT_NMI]  = nmi_req;
  assign req[SLOT_HI]   = ie & hi_pend & ~mask[2];
  assign req[SLOT_MID]  = ie & vmid_i  & ~mask[1];
  assign req[SLOT_LO]   = ie & vlo_i   & ~mask[0];
  assign req[SLOT_NVEC] = ie & nvec_i;

  irq_prio_sel #(.N(NUM_SRC)) u_sel (
    .req_i (req),
    .win_o (win)
  );

  always_comb begin
    src_d = SRC_NONE;
    vec_d = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      if (grant[s]) src_d = slot_to_src(s);
    end
    case (src_d)
      SRC_NMI: vec_d = VEC_NMI;
      SRC_HI:  vec_d = VEC_HI;
      SRC_MID: vec_d = VEC_MID;
      SRC_LO:  vec_d = VEC_LO;
      default: vec_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      ack_q  <= 1'b0;
      src_q  <= SRC_NONE;
      vec_q  <= '0;
    end else begin
      take_q <= any_grant;
      ack_q  <= grant[SLOT_NVEC];
      src_q  <= src_d;
      vec_q  <= vec_d;
    end
  end

  assign status_o = {serial_i, hi_pend, vmid_i, vlo_i, ie, mask};
  assign take_o   = take_q;
  assign ack_o    = ack_q;
  assign src_o    = src_q;
  assign vector_o = vec_q;
endmodule

// File: rtl/vec_irq_unit_chk.sv
module vec_irq_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        boundary_i,
  input logic        cmd_wr_i,
  input logic [4:0]  cmd_i,
  input logic        hi_rise,
  input logic [7:0]  status_o,
  input logic        take_o,
  input logic [2:0]  src_o,
  input logic        ack_o
);
  assert_boundary_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  assert_nvec_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (take_o && src_o == 3'd1));

  assert_ie_needed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o != 3'd5) |-> $past(status_o[3]));

  assert_ie_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o != 3'd5) |-> !status_o[3]);

  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !cmd_i[3]) |=> $stable(status_o[2:0]));

  assert_hi_served_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o == 3'd4 && !$past(hi_rise)) |-> !status_o[6]);
endmodule

bind vec_irq_unit vec_irq_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .cmd_wr_i   (cmd_wr_i),
  .cmd_i      (cmd_i),
  .hi_rise    (hi_rise),
  .status_o   (status_o),
  .take_o     (take_o),
  .src_o      (src_o),
  .ack_o      (ack_o)
);

// File: tb/vec_irq_unit_test.sv
module vec_irq_unit_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic boundary, nmi, vhi, vmid, vlo, nvec, en_op, dis_op, wr, ser;
  logic [4:0] cmd;
  logic [7:0] status;
  logic take, ack;
  logic [2:0] src;
  logic [15:0] vec;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary), .nmi_i(nmi),
    .vhi_i(vhi), .vmid_i(vmid), .vlo_i(vlo), .nvec_i(nvec),
    .en_op_i(en_op), .dis_op_i(dis_op), .cmd_wr_i(wr), .cmd_i(cmd),
    .serial_i(ser), .status_o(status), .take_o(take), .src_o(src),
    .vector_o(vec), .ack_o(ack)
  );

  // behavioural reference
  bit m_ie, m_hl, m_arm, m_nmi_p, m_hi_p, m_take, m_ack;
  bit [2:0] m_mask;
  int m_src;
  int m_vec;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ie = 0; m_hl = 0; m_arm = 0; m_nmi_p = 0; m_hi_p = 0;
      m_take = 0; m_ack = 0; m_mask = 3'b111; m_src = 0; m_vec = 0;
    end else begin
      int s;
      bit hi_r, nmi_r;
      hi_r = vhi && !m_hi_p;
      nmi_r = nmi && !m_nmi_p;
      s = 0;
      if (boundary) begin
        if (m_arm && nmi) s = 5;
        else if (m_ie && m_hl && !m_mask[2]) s = 4;
        else if (m_ie && vmid && !m_mask[1]) s = 3;
        else if (m_ie && vlo && !m_mask[0]) s = 2;
        else if (m_ie && nvec) s = 1;
      end
      m_take = (s != 0);
      m_ack = (s == 1);
      m_src = s;
      case (s)
        5: m_vec = 'h24; 4: m_vec = 'h3C; 3: m_vec = 'h34; 2: m_vec = 'h2C;
        default: m_vec = 0;
      endcase
      if (!nmi) m_arm = 0; else if (nmi_r) m_arm = 1; else if (s == 5) m_arm = 0;
      if (hi_r) m_hl = 1; else if (s == 4 || (wr && cmd[4])) m_hl = 0;
      if ((s >= 1 && s <= 4) || dis_op) m_ie = 0; else if (en_op) m_ie = 1;
      if (wr && cmd[3]) m_mask = cmd[2:0];
      m_hi_p = vhi; m_nmi_p = nmi;
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R2 status", status, {ser, m_hl, vmid, vlo, m_ie, m_mask});
      chk("R3 take", take, m_take);
      chk("R4 src", src, m_src);
      chk("R4 vector", vec, m_vec);
      chk("R4 ack", ack, m_ack);
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic clr();
    boundary = 0; en_op = 0; dis_op = 0; wr = 0; cmd = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5 * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr(); nmi = 0; vhi = 0; vmid = 0; vlo = 0; nvec = 0; ser = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1; cyc();
    chk("R1 reset status", status, 8'h07);
    chk("R1 reset take", take, 0);

    en_op = 1; wr = 1; cmd = 5'b01000; cyc(); clr();
    chk("R8 masks loaded / R9 enable", status, 8'h08);

    nvec = 1; boundary = 1; cyc(); clr(); nvec = 0;
    chk("R4 nvec ack", ack, 1);
    chk("R4 nvec src", src, 1);
    cyc();
    chk("R9 accept clears enable", status[3], 0);

    en_op = 1; vlo = 1; vmid = 1; cyc(); clr();
    chk("R2 pending levels", status[5:4], 2'b11);
    boundary = 1; cyc(); clr();
    chk("R4 middle over low", vec, 16'h0034);
    en_op = 1; vmid = 0; cyc(); clr();
    boundary = 1; cyc(); clr(); vlo = 0;
    chk("R7 level low taken", src, 2);

    en_op = 1; vhi = 1; cyc(); clr(); vhi = 0; cyc(); cyc();
    chk("R6 short pulse held", status[6], 1);
    boundary = 1; cyc(); clr();
    chk("R6 high vector", vec, 16'h003C);
    chk("R6 latch cleared by service", status[6], 0);

    wr = 1; cmd = 5'b00111; cyc(); clr();
    chk("R8 load bit clear ignored", status[2:0], 3'b000);
    wr = 1; cmd = 5'b01100; en_op = 1; cyc(); clr();
    vhi = 1; cyc(); vhi = 0; boundary = 1; cyc(); clr();
    chk("R10 masked high not taken", take, 0);
    chk("R10 still pending", status[6], 1);
    wr = 1; cmd = 5'b10100; cyc(); clr();
    chk("R6 clear bit empties latch", status[6], 0);
    chk("R8 mask kept", status[2:0], 3'b100);

    nmi = 1; cyc(); boundary = 1; cyc(); clr();
    chk("R5 nmi vector", vec, 16'h0024);
    chk("R5 nmi keeps enable", status[3], 1);
    boundary = 1; cyc(); clr();
    chk("R5 no retrigger while high", take, 0);
    nmi = 0; cyc(); nmi = 1; cyc(); boundary = 1; cyc(); clr();
    chk("R5 retrigger after drop", src, 5);
    nmi = 0;

    nvec = 1; repeat (4) cyc();
    chk("R3 no sample off boundary", take, 0);
    nvec = 0; ser = 1; cyc();
    chk("R2 serial bit", status[7], 1);

    for (int i = 0; i < 4000; i++) begin
      boundary = ($urandom_range(2) == 0);
      nmi  = ($urandom_range(5) == 0) ? ~nmi : nmi;
      vhi  = ($urandom_range(3) == 0);
      vmid = ($urandom_range(4) == 0);
      vlo  = ($urandom_range(4) == 0);
      nvec = ($urandom_range(3) == 0);
      en_op = ($urandom_range(3) == 0);
      dis_op = ($urandom_range(9) == 0);
      wr = ($urandom_range(7) == 0);
      cmd = 5'($urandom);
      ser = 1'($urandom);
      cyc();
    end
    clr();
    cyc();
    finish_run();
  end
endmodule